// File: doc/BRIEF.md
# Dual-Mode Compare PWM Timer Channel

This block is one timer channel with a free-running up-counter and four compare registers, called A, B, C and D. It drives four registered output pins. A simple write port loads the compare values, a byte of per-register output-level fields, and a control word. The control word selects one of two PWM schemes and enables counting.

In paired mode, two PWM waveforms come from two register pairs. The pair A/B drives pin 0 and the pair C/D drives pin 2. The first register of a pair sets the level reached on its match, and the second register sets the level reached on its own match. The counter restarts after register B matches.

In period/duty mode, a selectable register sets the period and clears the counter. Each of the other three registers sets one edge on its own pin, and every PWM pin falls back to its initial level at the end of each period. Writing the control word restarts the counter and reloads every pin. This gives software a clean, known starting point for a new waveform.

Top module: `pwm_timer`

## Requirements
- R1: After reset the counter reads 0, all four pins are 0, counting is disabled, and all compare and output-level fields are 0.
- R2: Register addresses:
  - Addresses 0 to 3 hold compare values A to D.
  - Address 4 is the control word: bit 0 enables counting, bit 1 selects the mode (0 paired, 1 period/duty), and bits 3:2 give the index of the period register.
  - Address 5 holds the output-level fields, two bits per register: A in bits 1:0, B in 3:2, C in 5:4 and D in 7:6. In each field, bit 0 is the initial level and bit 1 is the level driven on that register's match.
  - Writes to addresses 6 and 7 have no effect.
- R3: While enabled, the counter adds one per clock. In the cycle after the counter equals the period register, it reads 0 instead. The period register is B in paired mode and the selected index in period/duty mode. While disabled, the counter holds its value.
- R4: In the cycle after a control-word write, the counter reads 0 and every active pin shows the initial level of its own register. This applies even if a compare match fell in the write cycle.
- R5: In paired mode, when the counter equals A, pin 0 takes A's match level in the next cycle. When the counter equals B, pin 0 takes B's match level in the next cycle. Pin 2 behaves the same way with registers C and D.
- R6: In paired mode, if both registers of a pair hold the same value, the pair's pin never changes on a match.
- R7: In paired mode, pins 1 and 3 stay at 0.
- R8: In period/duty mode, when the counter equals a duty register, that register's pin takes its match level in the next cycle.
- R9: In period/duty mode, after a period match every PWM pin shows its own initial level.
- R10: In period/duty mode, the pin of the period register stays at 0.
- R11: In period/duty mode, a duty register equal to the period register leaves its pin at its initial level.
- R12: If the period register is rewritten below the current count, the counter runs up to 65535, wraps to 0, and then clears on the new period value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| pin_o | output | 4 | PWM output pins 0 to 3 |

## Verification
Two functions can fall in the same cycle, and the bench provokes both collisions on purpose.

The first collision is a control-word write landing in the cycle where the counter equals a duty register. The bench waits for that count, then writes the control word in that very cycle. It judges the result by requiring the initial level on the pin, not the match level, together with a zero count.

The second collision is a period clear coinciding with a duty match. It is provoked by giving a duty register the same value as the period register. The bench judges it by requiring that pin to stay at its initial level through many periods.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned NUM_CMP   = 4;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned SEL_W     = $clog2(NUM_CMP);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_OLVL = 3'd5;
  localparam logic [SEL_W-1:0]  PAIRED_PER = 2'd1;

  typedef enum logic {
    MODE_PAIRED = 1'b0,
    MODE_PERIOD = 1'b1
  } pwm_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0] per_sel;
    pwm_mode_e        mode;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_o,
  output logic [NUM_CMP-1:0][1:0]         olvl_o,
  output ctrl_t                           ctrl_o,
  output ctrl_t                           ctrl_nxt_o,
  output logic                            ctrl_wr_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  assign ctrl_wr_o  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign ctrl_nxt_o = ctrl_wr_o ? ctrl_t'(wr_data_i[CTRL_W-1:0]) : ctrl_o;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       cmp_o[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i))       cmp_o[i] <= wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       olvl_o[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_OLVL)        olvl_o[i] <= wr_data_i[2*i +: 2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= '0;
    else         ctrl_o <= ctrl_nxt_o;
  end
endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= '0;
    else if (run_i)  cnt_o <= clr_i ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/pwm_pin.sv
module pwm_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic load_i,
  input  logic restore_i,
  input  logic init_i,
  input  logic set_a_i,
  input  logic lvl_a_i,
  input  logic set_b_i,
  input  logic lvl_b_i,
  output logic pin_o
);
  // restore/load win over edges; edges of one pin never coincide when unequal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   pin_o <= 1'b0;
    else if (!active_i)            pin_o <= 1'b0;
    else if (load_i || restore_i)  pin_o <= init_i;
    else if (set_a_i)              pin_o <= lvl_a_i;
    else if (set_b_i)              pin_o <= lvl_b_i;
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [NUM_CMP-1:0]  pin_o
);
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
  logic [NUM_CMP-1:0][1:0]       olvl_q;
  ctrl_t                         ctrl_q, ctrl_nxt;
  logic                          ctrl_wr, run;
  logic [SEL_W-1:0]              per_idx;
  logic [NUM_CMP-1:0]            hit;
  logic                          per_hit;

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cmp_o      (cmp_q),
    .olvl_o     (olvl_q),
    .ctrl_o     (ctrl_q),
    .ctrl_nxt_o (ctrl_nxt),
    .ctrl_wr_o  (ctrl_wr)
  );

  assign run     = ctrl_q.en && !ctrl_wr;
  assign per_idx = (ctrl_q.mode == MODE_PERIOD) ? ctrl_q.per_sel : PAIRED_PER;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_hit
    assign hit[i] = run && (cnt_o == cmp_q[i]);
  end
  assign per_hit = hit[per_idx];

  pwm_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctrl_wr),
    .run_i  (run),
    .clr_i  (per_hit),
    .cnt_o  (cnt_o)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_pin
    localparam int unsigned MATE = i ^ 1;
    logic active, restore, set_a, lvl_a, set_b, lvl_b;

    if (i % 2 == 0) begin : g_lead
      always_comb begin
        if (ctrl_nxt.mode == MODE_PAIRED) begin
          active  = 1'b1;
          restore = 1'b0;
          set_a   = hit[i]    && (cmp_q[i] != cmp_q[MATE]);
          lvl_a   = olvl_q[i][1];
          set_b   = hit[MATE] && (cmp_q[i] != cmp_q[MATE]);
          lvl_b   = olvl_q[MATE][1];
        end else begin
          active  = (ctrl_nxt.per_sel != SEL_W'(i));
          restore = per_hit;
          set_a   = hit[i] && (cmp_q[i] != cmp_q[per_idx]);
          lvl_a   = olvl_q[i][1];
          set_b   = 1'b0;
          lvl_b   = 1'b0;
        end
      end
    end else begin : g_trail
      always_comb begin
        active  = (ctrl_nxt.mode == MODE_PERIOD) && (ctrl_nxt.per_sel != SEL_W'(i));
        restore = per_hit;
        set_a   = hit[i] && (cmp_q[i] != cmp_q[per_idx]);
        lvl_a   = olvl_q[i][1];
        set_b   = 1'b0;
        lvl_b   = 1'b0;
      end
    end

    pwm_pin u_pin (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (active),
      .load_i    (ctrl_wr),
      .restore_i (restore),
      .init_i    (olvl_q[i][0]),
      .set_a_i   (set_a),
      .lvl_a_i   (lvl_a),
      .set_b_i   (set_b),
      .lvl_b_i   (lvl_b),
      .pin_o     (pin_o[i])
    );
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [CNT_W-1:0]              cnt_o,
  input logic [NUM_CMP-1:0]            pin_o,
  input logic                          en_i,
  input logic                          mode_i,
  input logic [SEL_W-1:0]              sel_i,
  input logic [NUM_CMP-1:0][CNT_W-1:0] cmp_i
);
  logic             wr_ctl;
  logic [SEL_W-1:0] per;
  assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign per    = mode_i ? sel_i : PAIRED_PER;

  a_r3_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctl && !en_i) |=> $stable(cnt_o));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctl && en_i && cnt_o != cmp_i[per]) |=> cnt_o == $past(cnt_o) + 1'b1);

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ctl && en_i && cnt_o == cmp_i[per]) |=> cnt_o == '0);

  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl |=> cnt_o == '0);

  a_r6_equal_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !mode_i && cmp_i[0] == cmp_i[1]) |=> $stable(pin_o[0]));

  a_r7_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> (pin_o[1] == 1'b0 && pin_o[3] == 1'b0));

  a_r10_period_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> pin_o[sel_i] == 1'b0);
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .cnt_o     (cnt_o),
  .pin_o     (pin_o),
  .en_i      (ctrl_q.en),
  .mode_i    (ctrl_q.mode),
  .sel_i     (ctrl_q.per_sel),
  .cmp_i     (cmp_q)
);

// File: tb/sim_pwm_timer.sv
module sim_pwm_timer;
  localparam int W = 16;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cnt;
  logic [3:0]   pin;

  always #2 clk = ~clk;

  pwm_timer #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cnt_o(cnt), .pin_o(pin)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string req = "R1";

  // behavioural reference
  int m_cmp[4], m_ol[4], m_pin[4];
  int m_en = 0, m_mode = 0, m_sel = 0, m_cnt = 0;

  function automatic bit m_active(int i);
    return (m_mode == 0) ? (i % 2 == 0) : (i != m_sel);
  endfunction

  task automatic model_step();
    int np[4];
    bit hit[4];
    int per, nc;
    for (int i = 0; i < 4; i++) np[i] = m_pin[i];
    if (wr_en && wr_addr == 3'd4) begin
      m_en = wr_data[0]; m_mode = wr_data[1]; m_sel = wr_data[3:2];
      m_cnt = 0;
      for (int i = 0; i < 4; i++) m_pin[i] = m_active(i) ? (m_ol[i] & 1) : 0;
      return;
    end
    per = m_mode ? m_sel : 1;
    for (int i = 0; i < 4; i++) hit[i] = (m_en != 0) && (m_cnt == m_cmp[i]);
    nc = (m_en == 0) ? m_cnt : (hit[per] ? 0 : ((m_cnt + 1) & MASK));
    if (m_mode == 0) begin
      for (int a = 0; a < 4; a += 2) begin
        if (m_cmp[a] != m_cmp[a+1]) begin
          if (hit[a])        np[a] = m_ol[a] >> 1;
          else if (hit[a+1]) np[a] = m_ol[a+1] >> 1;
        end
      end
      np[1] = 0; np[3] = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (i == per)                                np[i] = 0;
        else if (hit[per])                           np[i] = m_ol[i] & 1;
        else if (hit[i] && m_cmp[i] != m_cmp[per])   np[i] = m_ol[i] >> 1;
      end
    end
    if (wr_en && wr_addr < 3'd4) m_cmp[wr_addr] = int'(wr_data);
    if (wr_en && wr_addr == 3'd5)
      for (int i = 0; i < 4; i++) m_ol[i] = (int'(wr_data) >> (2*i)) & 3;
    m_cnt = nc;
    for (int i = 0; i < 4; i++) m_pin[i] = np[i];
  endtask

  always @(posedge clk) if (rst_n) model_step();

  task automatic chk(string r, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", r, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req, "count vs model", int'(cnt), m_cnt);
      for (int i = 0; i < 4; i++) chk(req, "pin vs model", int'(pin[i]), m_pin[i]);
    end
  end

  // callers sit at a negedge
  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(int v);
    int k = 0;
    while (int'(cnt) != v && k < 70000) begin
      @(negedge clk);
      k++;
    end
    if (k >= 70000) chk(req, "count never reached", int'(cnt), v);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, got 0 expected 1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_ol[i] = 0; m_pin[i] = 0; end
    idle(3);
    chk("R1", "reset count", int'(cnt), 0);
    chk("R1", "reset pins", int'(pin), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1", "disabled after reset", int'(cnt), 0);

    // paired mode
    req = "R2";
    wr(3'd0, 16'd3); wr(3'd1, 16'd9); wr(3'd2, 16'd5); wr(3'd3, 16'd7);
    wr(3'd5, 16'h0092);   // A=10 B=00 C=01 D=10
    req = "R4";
    wr(3'd4, 16'h0001);
    chk("R4", "count after enable", int'(cnt), 0);
    chk("R4", "pin0 initial", int'(pin[0]), 0);
    chk("R4", "pin2 initial", int'(pin[2]), 1);
    req = "R5";
    wait_cnt(3); @(negedge clk);
    chk("R5", "pin0 after A match", int'(pin[0]), 1);
    wait_cnt(5); @(negedge clk);
    chk("R5", "pin2 after C match", int'(pin[2]), 0);
    wait_cnt(9); @(negedge clk);
    chk("R5", "pin0 after B match", int'(pin[0]), 0);
    chk("R3", "paired clear on B", int'(cnt), 0);
    idle(30);
    chk("R7", "pin1 quiet", int'(pin[1]), 0);
    chk("R7", "pin3 quiet", int'(pin[3]), 0);

    req = "R6";
    wr(3'd3, 16'd5);
    begin
      int p0;
      idle(2);
      p0 = int'(pin[2]);
      idle(40);
      chk("R6", "equal pair holds pin2", int'(pin[2]), p0);
    end

    req = "R2";
    wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
    idle(20);
    chk("R2", "pin1 after ignored writes", int'(pin[1]), 0);

    // period/duty mode, period on C, D equal to C
    req = "R8";
    wr(3'd0, 16'd4); wr(3'd1, 16'd10); wr(3'd2, 16'd12); wr(3'd3, 16'd12);
    wr(3'd5, 16'h00B9);   // A=01 B=10 C=11 D=10
    wr(3'd4, 16'h000B);
    chk("R4", "pin0 initial period mode", int'(pin[0]), 1);
    chk("R10", "period pin low", int'(pin[2]), 0);
    wait_cnt(4); @(negedge clk);
    chk("R8", "pin0 after duty match", int'(pin[0]), 0);
    wait_cnt(10); @(negedge clk);
    chk("R8", "pin1 after duty match", int'(pin[1]), 1);
    wait_cnt(12); @(negedge clk);
    chk("R9", "pin0 restored", int'(pin[0]), 1);
    chk("R9", "pin1 restored", int'(pin[1]), 0);
    chk("R3", "period clear", int'(cnt), 0);
    req = "R11";
    idle(60);
    chk("R11", "duty equal to period", int'(pin[3]), 0);
    chk("R10", "period pin still low", int'(pin[2]), 0);

    // control write colliding with duty match on A
    req = "R4";
    wait_cnt(4);
    wr(3'd4, 16'h000B);
    chk("R4", "write beats match pin0", int'(pin[0]), 1);
    chk("R4", "write beats match count", int'(cnt), 0);

    req = "R3";
    idle(7);
    wr(3'd4, 16'h000A);
    idle(10);
    chk("R3", "disabled count holds", int'(cnt), 0);

    // wrap: period moved below running count
    req = "R12";
    wr(3'd1, 16'd200); wr(3'd4, 16'h0001);
    wait_cnt(150);
    wr(3'd1, 16'd50);
    wait_cnt(MASK); @(negedge clk);
    chk("R12", "wrap to zero", int'(cnt), 0);
    wait_cnt(50); @(negedge clk);
    chk("R12", "clear on new period", int'(cnt), 0);
    idle(5);
    finish_run();
  end
endmodule